// File: doc/BRIEF.md
# Systolic Montgomery Modular Multiplier

This block computes the radix-2 Montgomery product of two operands, A·B·2^(-n) mod M, for an odd n-bit modulus M, where n is the parameter `N`. It is meant to be the core of a modular exponentiation engine. The surrounding controller moves values into and out of the Montgomery domain and applies any final correction. The datapath is a row of identical bit slices. Each slice reduces its own column with two one-bit full adders, and its carries pass only to the next slice up.

A one-cycle `start` strobe loads the operands. For the next n cycles the block takes one multiplier bit per cycle, least significant first. In each of these cycles it forms the quotient bit from the low column and folds `a_i·B + q_i·M` into a carry-save accumulator, then halves the accumulator. The block then resolves the redundant accumulator into binary with a single serial full adder, one result bit per clock. After that it waits for a fixed number of cycles, so that the latency from start to result is always 2n+11 cycles. A one-cycle `done` pulse marks the result as valid.

Top module: `mont_mul_systolic`

## Requirements
- R1: With M odd and A, B < M, the value on `result` while `done` is high is congruent to A·B·2^(-N) modulo M, and it is less than 2·M.
- R2: `done` is high for exactly one cycle. If `start` is sampled high at a rising edge while the block is idle, `done` becomes high after the 2N+11th rising edge that follows, and it is low after every earlier edge.
- R3: While an operation is in progress, a high `start` is ignored. The result and the timing of `done` stay those of the operation that is running.
- R4: After reset `done` is 0 and `result` is 0.
- R5: If either operand is zero, the result is 0.
- R6: Operands at the top of the range, A = M-1 and B = M-1, give a correct result under R1.
- R7: Between the `done` pulse and the next accepted `start`, `result` keeps its value.
- R8: The quotient bit of each step is the parity of the low column (accumulator plus a_i·B), so no precomputed inverse of M is used. Each step leaves an even sum that is then halved exactly, and no carry escapes the top slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that loads the operands when the block is idle |
| a_in | input | N | Multiplier A, scanned one bit per cycle from the LSB |
| b_in | input | N | Multiplicand B |
| m_in | input | N | Odd modulus M |
| result | output | N+1 | Montgomery product, below 2·M |
| done | output | 1 | One-cycle pulse when `result` is valid |

## Verification
The hardest case to reach from the ports is a `start` strobe that arrives in the middle of a run. To show that it is ignored, the bench must check both the result and the exact cycle of `done` for the operation that is already running. The stimulus raises `start` a few cycles into a run with unrelated operands. The bench then compares `done` against its own cycle model on every clock and checks the product against a behavioural Montgomery reduction of the original operands. The extreme operand values M-1 and 0 are driven under several random odd moduli, so that the accumulator is pushed near its 2·M bound and the top-slice carries are exercised.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_CONV = 2'd2,
        PH_WAIT = 2'd3
    } phase_e;
endpackage

// File: rtl/mont_fa.sv
module mont_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/mont_pe.sv
// One bit slice: two full-adder levels compress s + c + x + y for one column.
module mont_pe (
    input  logic s_bit,
    input  logic c_bit,
    input  logic x_bit,
    input  logic y_bit,
    input  logic u_in,
    output logic u_out,
    output logic v_bit,
    output logic w_out
);
    logic t_bit;

    mont_fa u_fa_lo (.a(s_bit), .b(c_bit), .ci(x_bit), .s(t_bit), .co(u_out));
    mont_fa u_fa_hi (.a(t_bit), .b(u_in),  .ci(y_bit), .s(v_bit), .co(w_out));
endmodule

// File: rtl/mont_cs_array.sv
// Linear row of slices; carries only move from slice j to slice j+1.
module mont_cs_array #(
    parameter int W = 18
) (
    input  logic [W-1:0] s_vec,
    input  logic [W-1:0] c_vec,
    input  logic [W-1:0] x_vec,
    input  logic [W-1:0] y_vec,
    output logic [W-1:0] v_vec,
    output logic [W-1:0] w_vec,
    output logic         top_ovf
);
    logic [W:0] u_chain;
    logic [W:0] w_chain;

    assign u_chain[0] = 1'b0;
    assign w_chain[0] = 1'b0;

    for (genvar j = 0; j < W; j++) begin : g_slice
        mont_pe u_pe (
            .s_bit (s_vec[j]),
            .c_bit (c_vec[j]),
            .x_bit (x_vec[j]),
            .y_bit (y_vec[j]),
            .u_in  (u_chain[j]),
            .u_out (u_chain[j+1]),
            .v_bit (v_vec[j]),
            .w_out (w_chain[j+1])
        );
    end

    assign w_vec   = w_chain[W-1:0];
    assign top_ovf = u_chain[W] | w_chain[W];
endmodule

// File: rtl/mont_mul_systolic.sv
module mont_mul_systolic #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic [N-1:0] m_in,
    output logic [N:0]   result,
    output logic         done
);
    import mm_pkg::*;

    localparam int W     = N + 2;
    localparam int LAT   = 2 * N + 11;
    localparam int CW    = $clog2(LAT + 1);
    localparam int LAST  = LAT - 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [N-1:0]  a;
        logic [N-1:0]  b;
        logic [N-1:0]  m;
        logic [N:0]    s;
        logic [N:0]    c;
        logic          cy;
        logic [N:0]    res;
    } st_t;

    st_t    st_q, st_d;
    phase_e ph;

    always_comb begin
        if (!st_q.busy)                    ph = PH_IDLE;
        else if (st_q.cnt < CW'(N))        ph = PH_STEP;
        else if (st_q.cnt <= CW'(2 * N))   ph = PH_CONV;
        else                               ph = PH_WAIT;
    end

    // Step operands: a_i gates B, the column parity picks the quotient bit.
    logic         a_bit, q_bit;
    logic [W-1:0] s_ext, c_ext, x_vec, y_vec, v_vec, w_vec;
    logic         top_ovf;

    assign a_bit = st_q.a[0];
    assign q_bit = st_q.s[0] ^ st_q.c[0] ^ (a_bit & st_q.b[0]);
    assign s_ext = {1'b0, st_q.s};
    assign c_ext = {1'b0, st_q.c};
    assign x_vec = a_bit ? {2'b00, st_q.b} : '0;
    assign y_vec = q_bit ? {2'b00, st_q.m} : '0;

    mont_cs_array #(.W(W)) u_array (
        .s_vec   (s_ext),
        .c_vec   (c_ext),
        .x_vec   (x_vec),
        .y_vec   (y_vec),
        .v_vec   (v_vec),
        .w_vec   (w_vec),
        .top_ovf (top_ovf)
    );

    // Serial resolution of the carry-save pair, LSB first.
    logic conv_bit, conv_cy;
    mont_fa u_fa_conv (
        .a  (st_q.s[0]),
        .b  (st_q.c[0]),
        .ci (st_q.cy),
        .s  (conv_bit),
        .co (conv_cy)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                    st_d.a    = a_in;
                    st_d.b    = b_in;
                    st_d.m    = m_in;
                    st_d.s    = '0;
                    st_d.c    = '0;
                    st_d.cy   = 1'b0;
                end
            end
            PH_STEP: begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.a   = st_q.a >> 1;
                st_d.s   = v_vec[W-1:1];
                st_d.c   = w_vec[W-1:1];
            end
            PH_CONV: begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.res = {conv_bit, st_q.res[N:1]};
                st_d.s   = st_q.s >> 1;
                st_d.c   = st_q.c >> 1;
                st_d.cy  = conv_cy;
            end
            PH_WAIT: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(LAST)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
    assign done   = st_q.done;

    // R2: the completion flag is a single-cycle pulse.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R3: a run keeps its operands and stays busy until its last count.
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != CW'(LAST)) |=>
            (st_q.busy && $stable(st_q.m) && $stable(st_q.b)));

    // R8: each step leaves an even sum and nothing past the top slice.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_STEP) |-> (!top_ovf && !v_vec[0]));

    // R1: the serial adder ends with no carry left over.
    p_conv_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == CW'(2 * N + 1)) |-> !st_q.cy);

    // R1: the delivered value stays under twice the modulus.
    p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.res < {st_q.m, 1'b0}));

    // R7: with no accepted start, the idle result does not move.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start) |=> $stable(st_q.res));
endmodule

// File: tb/tb_mont_mul_systolic.sv
`timescale 1ns/1ps
module tb_mont_mul_systolic;
    localparam int N   = 16;
    localparam int LAT = 2 * N + 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] a_in = '0, b_in = '0, m_in = '0;
    logic [N:0]   result;
    logic         done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    mont_mul_systolic #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in), .m_in(m_in),
        .result(result), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reduction: add M when odd, halve, N times.
    function automatic longint mont_ref(input longint a, input longint b, input longint m);
        longint t = a * b;
        for (int i = 0; i < N; i++) begin
            if (t[0]) t = t + m;
            t = t >>> 1;
        end
        return t % m;
    endfunction

    task automatic run_op(input longint a, input longint b, input longint m, input bit poke, input string req);
        longint exp_v;
        longint held;
        int     late = 0;
        exp_v = mont_ref(a, b, m);
        @(negedge clk);
        a_in = a[N-1:0]; b_in = b[N-1:0]; m_in = m[N-1:0]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= LAT; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && k == 4) begin
                // R3: mid-run strobe with unrelated operands
                a_in = '1; b_in = 16'h1234; m_in = 16'h0007; start = 1'b1;
            end
            if (poke && k == 5) start = 1'b0;
            if (done != (k == LAT)) late++;
        end
        check(late == 0, "R2 done cycle", late, 0);
        check((result % m) == exp_v, req, result % m, exp_v);
        check(result < 2 * m, "R1 bound", result, 2 * m);
        held = result;
        @(negedge clk);
        check(done == 1'b0, "R2 pulse width", done, 0);
        repeat (3) @(negedge clk);
        check(result == held, "R7 hold", result, held);
    endtask

    initial begin
        #(200000 * 5);
        if (!ended) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        longint m;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R4 done", done, 0);
        check(result == '0, "R4 result", result, 0);
        rst_n = 1'b1;
        run_op(3, 5, 13, 0, "R1 small");
        run_op(0, 200, 251, 0, "R5 A=0");
        run_op(177, 0, 251, 0, "R5 B=0");
        run_op(65520, 65520, 65521, 0, "R6 max operands");
        run_op(40000, 30000, 65521, 1, "R3 start ignored");
        for (int i = 0; i < 10; i++) begin
            m = longint'($urandom_range(65535, 3)) | 1;
            run_op(m - 1, m - 1, m, 0, "R6 random M");
            run_op(longint'($urandom) % m, longint'($urandom) % m, m, 0, "R1 R8 random");
            run_op(longint'($urandom) % m, m - 1, m, (i % 3) == 0, "R1 R3 mixed");
        end
        ended = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule